// File: doc/BRIEF.md
# Trapping Integer Add/Subtract Unit

This block is the integer add/subtract stage of a processor execute pipe. It works on 32-bit two's-complement values. The second operand is either a register value or a sign-widened 16-bit immediate. A 3-bit operation code chooses addition, subtraction or immediate addition. Each of these comes in a trapping form and a non-trapping form. Subtraction uses the same adder as addition: the second operand is bit-inverted and a carry-in of one is supplied.

The sum and the result-write enable are combinational and appear in the same cycle as the operation. A trapping operation whose signed result does not fit in the word produces no write. One clock edge later it raises a single-cycle exception pulse, and a register captures the address of the faulting instruction. That saved address stays put until a clear input is pulsed, so an exception handler can read it and resume execution. The non-trapping forms return the wrapped sum and never raise an exception.

Top module: `trap_addsub`

## Requirements
- R1: Codes 000 (trapping) and 001 (non-trapping) produce `result = rs_val + rt_val` modulo 2^32.
- R2: Codes 010 (trapping) and 011 (non-trapping) produce `result = rs_val - rt_val` modulo 2^32. The value is formed as rs_val plus the bit-inverted rt_val plus one.
- R3: Codes 100 (trapping) and 101 (non-trapping) add rs_val to `imm16` widened to 32 bits. Bit 15 of `imm16` is copied into bits 31..16.
- R4: An addition overflows only when both addends have the same sign and the sum has the other sign. Addends of opposite sign never overflow.
- R5: A subtraction overflows only when the operands differ in sign and the result sign differs from the sign of rs_val. Operands of equal sign never overflow.
- R6: For a trapping code (000, 010, 100) with `op_valid` high and overflow, `wr_en` is low in that cycle. For any other operation with `op_valid` high, `wr_en` is high.
- R7: The non-trapping codes (001, 011, 101) return the wrapped result with `wr_en` high and never raise `exc_pulse`.
- R8: A trapping overflow sets `exc_pulse` high for exactly the cycle after the operation. In that same cycle, `exc_pc` holds the `pc_in` value of the faulting operation.
- R9: `exc_pc` keeps its value until `clr_exc` is sampled high, after which it reads zero. If a fault and a clear are sampled at the same edge, the address of the new fault is kept.
- R10: The unused codes 110 and 111 act as a non-trapping register add.
- R11: After reset, `exc_pulse` is low and `exc_pc` is zero.
- R12: With `op_valid` low, `wr_en` is low and no exception is raised, even if the operands would overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select (see R1-R3, R10) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate operand |
| pc_in | input | 32 | Address of the instruction presented |
| clr_exc | input | 1 | Clears the saved fault address |
| result | output | 32 | Sum or difference |
| wr_en | output | 1 | Destination register write enable |
| exc_pulse | output | 1 | One-cycle overflow exception |
| exc_pc | output | 32 | Saved address of the faulting instruction |

## Verification
The bench applies operands at the sign boundary: largest positive plus one, most negative minus one, zero minus the most negative value, and minus one minus the largest positive value. A design with a wrong overflow rule either traps where the result fits, or lets an out-of-range result be written. Subtracting the most negative value checks that overflow is judged from the inverted operand and not from a negated one; a design that got this wrong would miss that trap. Negative immediates catch zero-extension, because the upper half of the result would come out wrong. Other directed tests cover the reserved codes, a fault while `op_valid` is low, holding and clearing the saved address, and a fault arriving on the same edge as a clear. These catch designs that trap on the wrong codes, lose the saved address, or drop a fault when a clear coincides.

// File: rtl/trap_addsub_pkg.sv
package trap_addsub_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'b000,
      OP_ADDU  = 3'b001,
      OP_SUB   = 3'b010,
      OP_SUBU  = 3'b011,
      OP_ADDI  = 3'b100,
      OP_ADDIU = 3'b101
   } alu_op_e;

   typedef struct packed {
      logic is_sub;
      logic use_imm;
      logic traps;
   } op_ctl_t;

   // Reserved codes fall back to a non-trapping register add.
   function automatic op_ctl_t decode_op(input logic [2:0] code);
      op_ctl_t c;
      c = '{is_sub: 1'b0, use_imm: 1'b0, traps: 1'b0};
      case (code)
         OP_ADD:   c.traps   = 1'b1;
         OP_SUB:   begin c.is_sub = 1'b1; c.traps = 1'b1; end
         OP_SUBU:  c.is_sub  = 1'b1;
         OP_ADDI:  begin c.use_imm = 1'b1; c.traps = 1'b1; end
         OP_ADDIU: c.use_imm = 1'b1;
         default:  ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  imm_in,
   output logic [OUT_W-1:0] imm_out
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_out = {{PAD_W{imm_in[IN_W-1]}}, imm_in};
      end else begin : g_same
         assign imm_out = imm_in[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
   parameter int W = 32
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         do_sub,
   output logic [W-1:0] sum,
   output logic         ovf
);
   localparam int MSB = W - 1;

   logic [W-1:0] opb_eff;

   // Subtract by inverting and injecting a carry of one.
   assign opb_eff = do_sub ? ~opb : opb;
   assign sum     = opa + opb_eff + W'(do_sub);
   assign ovf     = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  logic [ADDR_W-1:0] fault_pc,
   input  logic              clr,
   output logic              pulse,
   output logic [ADDR_W-1:0] saved_pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse    <= 1'b0;
         saved_pc <= '0;
      end else begin
         pulse <= fault;
         if (fault)
            saved_pc <= fault_pc;
         else if (clr)
            saved_pc <= '0;
      end
   end
endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
   import trap_addsub_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] rs_val,
   input  logic [DATA_W-1:0] rt_val,
   input  logic [IMM_W-1:0]  imm16,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              clr_exc,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              exc_pulse,
   output logic [ADDR_W-1:0] exc_pc
);
   generate
      if (IMM_W > DATA_W || IMM_W < 1) begin : g_bad_imm
         $error("trap_addsub: IMM_W must be between 1 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("trap_addsub: DATA_W must be at least 2");
      end
   endgenerate

   op_ctl_t           ctl;
   logic [DATA_W-1:0] imm_wide;
   logic [DATA_W-1:0] opb;
   logic              ovf;
   logic              fault;

   assign ctl = decode_op(op_code);

   imm_widen #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_widen (
      .imm_in (imm16),
      .imm_out(imm_wide)
   );

   assign opb = ctl.use_imm ? imm_wide : rt_val;

   addsub_core #(.W(DATA_W)) u_core (
      .opa   (rs_val),
      .opb   (opb),
      .do_sub(ctl.is_sub),
      .sum   (result),
      .ovf   (ovf)
   );

   assign fault = op_valid && ctl.traps && ovf;
   assign wr_en = op_valid && !fault;

   fault_latch #(.ADDR_W(ADDR_W)) u_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault   (fault),
      .fault_pc(pc_in),
      .clr     (clr_exc),
      .pulse   (exc_pulse),
      .saved_pc(exc_pc)
   );
endmodule

// File: rtl/trap_addsub_chk.sv
module trap_addsub_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic [IMM_W-1:0]  imm16,
   input logic [ADDR_W-1:0] pc_in,
   input logic              clr_exc,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              exc_pulse,
   input logic [ADDR_W-1:0] exc_pc
);
   logic nontrap_code;
   assign nontrap_code = op_code[0] || (op_code[2:1] == 2'b11);

   // R2: the non-trapping subtract yields the plain difference
   assert_sub_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b011) |-> (result == rs_val - rt_val));

   // R3: immediate add uses the sign-widened immediate
   assert_imm_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'b101) |->
      (result == rs_val + {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16}));

   // R7, R10: non-trapping codes always write when valid
   assert_nontrap_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && nontrap_code) |-> wr_en);

   // R8: a pulse only follows a valid operation whose write was withheld
   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> $past(op_valid && !wr_en));

   // R8: the saved address is the faulting instruction's address
   assert_pulse_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> (exc_pc == $past(pc_in)));

   // R9: without a fault or a clear the saved address holds
   assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_pulse && !$past(clr_exc)) |-> $stable(exc_pc));

   // R9: a clear with no new fault zeroes the saved address
   assert_pc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_exc) && !exc_pulse) |-> (exc_pc == '0));

   // R12: nothing is written while idle
   assert_idle_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !wr_en);
endmodule

bind trap_addsub trap_addsub_chk #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16), .pc_in(pc_in),
   .clr_exc(clr_exc), .result(result), .wr_en(wr_en),
   .exc_pulse(exc_pulse), .exc_pc(exc_pc)
);

// File: tb/trap_addsub_tb.sv
module trap_addsub_tb;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      logic [31:0] res;
      logic        wr;
      logic        exc;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{3'b000, 32'h0000_0005, 32'h0000_0001, 16'h0000, 32'h0000_0006, 1'b1, 1'b0}, // R1
      '{3'b000, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b0, 1'b1}, // R4 pos+pos
      '{3'b000, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R4 neg+neg
      '{3'b000, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0000, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 mixed
      '{3'b001, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b1, 1'b0}, // R7 addu wraps
      '{3'b010, 32'h0000_0003, 32'h0000_0002, 16'h0000, 32'h0000_0001, 1'b1, 1'b0}, // R2
      '{3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h8000_0000, 1'b0, 1'b1}, // R5 pos-neg
      '{3'b010, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R5 neg-pos
      '{3'b010, 32'h0000_0000, 32'h8000_0000, 16'h0000, 32'h8000_0000, 1'b0, 1'b1}, // R5 0-min
      '{3'b010, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0000, 32'h8000_0000, 1'b1, 1'b0}, // R5 fits
      '{3'b011, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R7 subu
      '{3'b100, 32'h0000_0010, 32'h0000_0000, 16'hFFFF, 32'h0000_000F, 1'b1, 1'b0}, // R3 neg imm
      '{3'b100, 32'h7FFF_FFFF, 32'h0000_0000, 16'h0001, 32'h8000_0000, 1'b0, 1'b1}, // R3 R6 trap
      '{3'b101, 32'h0000_0000, 32'h0000_0000, 16'h8000, 32'hFFFF_8000, 1'b1, 1'b0}, // R3 addiu
      '{3'b110, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b1, 1'b0}, // R10
      '{3'b111, 32'h0000_0003, 32'h0000_0004, 16'h1234, 32'h0000_0007, 1'b1, 1'b0}, // R10
      '{3'b010, 32'h8000_0000, 32'h8000_0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}  // R5 same sign
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [15:0] imm16 = '0;
   logic [31:0] pc_in = '0;
   logic        clr_exc = 1'b0;
   logic [31:0] result;
   logic        wr_en;
   logic        exc_pulse;
   logic [31:0] exc_pc;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] last_fault_pc = '0;

   always #4 clk = ~clk;

   trap_addsub u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16), .pc_in(pc_in),
      .clr_exc(clr_exc), .result(result), .wr_en(wr_en),
      .exc_pulse(exc_pulse), .exc_pc(exc_pc)
   );

   task automatic check(input logic ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] imm,
                        input logic [31:0] pc, input logic clr);
      @(negedge clk);
      op_valid = v; op_code = op; rs_val = a; rt_val = b;
      imm16 = imm; pc_in = pc; clr_exc = clr;
      #1;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check(exc_pulse == 1'b0, "R11 exc_pulse", {31'd0, exc_pulse}, 32'd0);
      check(exc_pc == 32'd0, "R11 exc_pc", exc_pc, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm,
               32'h1000 + 32'(i * 4), 1'b0);
         check(result == VECS[i].res, $sformatf("R1/R2/R3 result vec %0d", i),
               result, VECS[i].res);
         check(wr_en == VECS[i].wr, $sformatf("R6 wr_en vec %0d", i),
               {31'd0, wr_en}, {31'd0, VECS[i].wr});
         @(posedge clk); #1;
         check(exc_pulse == VECS[i].exc, $sformatf("R8 exc_pulse vec %0d", i),
               {31'd0, exc_pulse}, {31'd0, VECS[i].exc});
         if (VECS[i].exc) last_fault_pc = 32'h1000 + 32'(i * 4);
         check(exc_pc == last_fault_pc, $sformatf("R8 R9 exc_pc vec %0d", i),
               exc_pc, last_fault_pc);
      end

      // R12: an overflowing trapping add while idle does nothing
      drive(1'b0, 3'b000, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h2000, 1'b0);
      check(wr_en == 1'b0, "R12 wr_en idle", {31'd0, wr_en}, 32'd0);
      @(posedge clk); #1;
      check(exc_pulse == 1'b0, "R12 no exc idle", {31'd0, exc_pulse}, 32'd0);
      check(exc_pc == last_fault_pc, "R9 hold while idle", exc_pc, last_fault_pc);

      // R9: clear zeroes the saved address
      drive(1'b0, 3'b000, 32'h0, 32'h0, 16'h0, 32'h2004, 1'b1);
      @(posedge clk); #1;
      check(exc_pc == 32'd0, "R9 clear", exc_pc, 32'd0);

      // R8: new fault captured
      drive(1'b1, 3'b010, 32'h0, 32'h8000_0000, 16'h0, 32'h2008, 1'b0);
      @(posedge clk); #1;
      check(exc_pc == 32'h2008, "R8 capture", exc_pc, 32'h2008);

      // R9: fault and clear on the same edge keeps the new address
      drive(1'b1, 3'b000, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h200C, 1'b1);
      @(posedge clk); #1;
      check(exc_pulse == 1'b1, "R9 fault with clear pulse", {31'd0, exc_pulse}, 32'd1);
      check(exc_pc == 32'h200C, "R9 fault beats clear", exc_pc, 32'h200C);

      // R8: pulse lasts one cycle only
      drive(1'b0, 3'b001, 32'h0, 32'h0, 16'h0, 32'h2010, 1'b0);
      @(posedge clk); #1;
      check(exc_pulse == 1'b0, "R8 single cycle", {31'd0, exc_pulse}, 32'd0);
      check(exc_pc == 32'h200C, "R9 hold after pulse", exc_pc, 32'h200C);

      // R7: subu overflow-style case never raises an exception
      drive(1'b1, 3'b011, 32'h0, 32'h8000_0000, 16'h0, 32'h2014, 1'b0);
      check(result == 32'h8000_0000 && wr_en, "R7 subu wrap", result, 32'h8000_0000);
      @(posedge clk); #1;
      check(exc_pulse == 1'b0, "R7 subu no exc", {31'd0, exc_pulse}, 32'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule